// File: doc/BRIEF.md
# Broadcast Frame Statistics Counters

This block keeps two frame counters for an Ethernet MAC. One counts broadcast frames that were received cleanly. The other counts broadcast frames that were transmitted successfully. The receive and transmit MACs each send a single-cycle end-of-frame pulse. Each pulse carries the 48-bit destination address and, on the receive side, a vector of error flags. A frame counts only when its destination address is all ones. A received frame must also have no error flag set. A global enable input gates all counting.

Software reads the counters through a byte-wide register port with a read strobe. A read returns the current value and clears that counter. A counter rolls over from its maximum value back to zero. A sticky update interrupt is raised when either counter reaches a fixed level. The interrupt stays set until a write-one-to-clear strobe clears it.

Top module: `bcast_stats`

## Requirements
- R1: After reset, both counters read 0x00 and `upd_irq` is 0.
- R2: While `rd_stb` is 1, `rd_data` shows the receive counter when `rd_ofs` is 0x7D and the transmit counter when `rd_ofs` is 0x7C. The value appears in the same cycle as the strobe.
- R3: An event counts only when its destination address is 0xFFFFFFFFFFFF. Frames sent to any other address, multicast ones included, leave the counter unchanged.
- R4: A receive event does not count if any bit of `rx_err` is set. The bits are: bit 0 frame too long, bit 1 FCS error, bit 2 length error, bit 3 alignment error, bit 4 internal loss such as overrun.
- R5: When a counter holds 0xFF, the next counted event sets it to 0x00.
- R6: A read clears the counter that was read, and the clear takes effect at the clock edge ending the strobe cycle.
- R7: While `stat_en` is 0, events leave both counters unchanged.
- R8: `upd_irq` goes to 1 at the clock edge where either counter changes to 0xC0 because of a counted event.
- R9: `upd_irq` stays 1 until a cycle with `irq_clr` = 1. If a new 0xC0 crossing happens in that same cycle, the set wins.
- R10: If a read and a counted event hit the same counter in one cycle, the read returns the old value and the counter becomes 0x01.
- R11: A strobe to any offset other than 0x7C or 0x7D returns 0x00 and changes no counter. `rd_data` is 0x00 whenever `rd_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_en | input | 1 | Counting enable |
| rx_evt | input | 1 | Receive end-of-frame pulse |
| rx_da | input | 48 | Receive destination address |
| rx_err | input | 5 | Receive error flags (see R4) |
| tx_evt | input | 1 | Transmit successful-frame pulse |
| tx_da | input | 48 | Transmit destination address |
| rd_stb | input | 1 | Register read strobe |
| rd_ofs | input | 8 | Register offset |
| rd_data | output | 8 | Read data |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| upd_irq | output | 1 | Sticky statistics-update interrupt |

## Verification
Directed sequences separate the filtering cases from each other:
- all-ones addresses against near-miss and multicast addresses;
- each error bit set on its own;
- events with counting disabled;
- long runs that cross 0xC0 and 0xFF.

Further directed cases cover collisions between a read, an event and the interrupt clear, which tell apart the old-value, set-wins and clear orderings. A seeded random phase then mixes events, addresses, error vectors, reads to mapped and unmapped offsets, and clears. A bench model predicts every read value and the interrupt level in each cycle.

// File: rtl/bcast_stats_pkg.sv
package bcast_stats_pkg;
   // channel indices
   localparam int unsigned CH_TX = 0;
   localparam int unsigned CH_RX = 1;
   localparam int unsigned N_CH  = 2;
   // receive error flag positions
   localparam int unsigned ERR_LONG  = 0;
   localparam int unsigned ERR_FCS   = 1;
   localparam int unsigned ERR_LEN   = 2;
   localparam int unsigned ERR_ALIGN = 3;
   localparam int unsigned ERR_OVR   = 4;
   localparam int unsigned N_ERR     = 5;
endpackage

// File: rtl/bcast_filter.sv
module bcast_filter #(
   parameter int unsigned DA_W = 48,
   parameter int unsigned ERR_W = 5,
   parameter logic [ERR_W-1:0] ERR_MASK = '1
) (
   input  logic             stat_en,
   input  logic             evt,
   input  logic [DA_W-1:0]  da,
   input  logic [ERR_W-1:0] err,
   output logic             cnt_inc
);
   logic is_bcast;
   logic err_free;

   assign is_bcast = &da;
   assign err_free = ~|(err & ERR_MASK);
   assign cnt_inc  = stat_en & evt & is_bcast & err_free;
endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
   parameter int unsigned CNT_W = 8,
   parameter logic [CNT_W-1:0] IRQ_AT = 8'hC0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic [CNT_W-1:0] cnt_plus;

   assign cnt_plus = cnt_q + ONE;

   always_comb begin
      if (clr)
         cnt_d = inc ? ONE : '0;
      else if (inc)
         cnt_d = cnt_plus;
      else
         cnt_d = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else
         cnt_q <= cnt_d;
   end

   assign hit = inc & ~clr & (cnt_plus == IRQ_AT);
   assign cnt = cnt_q;
endmodule

// File: rtl/stat_irq.sv
module stat_irq #(
   parameter int unsigned N_SRC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] hit,
   input  logic             clr,
   output logic             irq
);
   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else if (|hit)
         irq_q <= 1'b1;
      else if (clr)
         irq_q <= 1'b0;
   end

   assign irq = irq_q;
endmodule

// File: rtl/bcast_stats.sv
module bcast_stats
   import bcast_stats_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned DA_W  = 48,
   parameter int unsigned OFS_W = 8,
   parameter logic [OFS_W-1:0] OFS_TX = 8'h7C,
   parameter logic [OFS_W-1:0] OFS_RX = 8'h7D,
   parameter logic [CNT_W-1:0] IRQ_AT = 8'hC0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stat_en,
   input  logic             rx_evt,
   input  logic [DA_W-1:0]  rx_da,
   input  logic [N_ERR-1:0] rx_err,
   input  logic             tx_evt,
   input  logic [DA_W-1:0]  tx_da,
   input  logic             rd_stb,
   input  logic [OFS_W-1:0] rd_ofs,
   output logic [CNT_W-1:0] rd_data,
   input  logic             irq_clr,
   output logic             upd_irq
);
   if (CNT_W < 2) begin : g_bad_w
      $error("bcast_stats: CNT_W must be at least 2");
   end
   if (OFS_TX == OFS_RX) begin : g_bad_ofs
      $error("bcast_stats: counter offsets must differ");
   end
   if (IRQ_AT == '0) begin : g_bad_lvl
      $error("bcast_stats: IRQ_AT must be nonzero");
   end

   logic [N_CH-1:0]             evt_v;
   logic [N_CH-1:0][DA_W-1:0]   da_v;
   logic [N_CH-1:0][N_ERR-1:0]  err_v;
   logic [N_CH-1:0][OFS_W-1:0]  ofs_v;
   logic [N_CH-1:0]             inc_v;
   logic [N_CH-1:0]             sel_v;
   logic [N_CH-1:0]             hit_v;
   logic [N_CH-1:0][CNT_W-1:0]  cnt_v;
   logic [CNT_W-1:0]            cnt_tx_w;
   logic [CNT_W-1:0]            cnt_rx_w;

   assign evt_v[CH_TX] = tx_evt;
   assign evt_v[CH_RX] = rx_evt;
   assign da_v[CH_TX]  = tx_da;
   assign da_v[CH_RX]  = rx_da;
   assign err_v[CH_TX] = '0;
   assign err_v[CH_RX] = rx_err;
   assign ofs_v[CH_TX] = OFS_TX;
   assign ofs_v[CH_RX] = OFS_RX;

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      localparam logic [N_ERR-1:0] MASK = (ch == CH_RX) ? {N_ERR{1'b1}} : {N_ERR{1'b0}};

      assign sel_v[ch] = rd_stb & (rd_ofs == ofs_v[ch]);

      bcast_filter #(
         .DA_W(DA_W), .ERR_W(N_ERR), .ERR_MASK(MASK)
      ) u_flt (
         .stat_en(stat_en), .evt(evt_v[ch]), .da(da_v[ch]),
         .err(err_v[ch]), .cnt_inc(inc_v[ch])
      );

      stat_counter #(
         .CNT_W(CNT_W), .IRQ_AT(IRQ_AT)
      ) u_cnt (
         .clk(clk), .rst_n(rst_n), .inc(inc_v[ch]), .clr(sel_v[ch]),
         .cnt(cnt_v[ch]), .hit(hit_v[ch])
      );
   end

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < N_CH; c++) begin
         if (sel_v[c])
            rd_data = cnt_v[c];
      end
   end

   stat_irq #(.N_SRC(N_CH)) u_irq (
      .clk(clk), .rst_n(rst_n), .hit(hit_v), .clr(irq_clr), .irq(upd_irq)
   );

   assign cnt_tx_w = cnt_v[CH_TX];
   assign cnt_rx_w = cnt_v[CH_RX];
endmodule

// File: rtl/bcast_stats_chk.sv
module bcast_stats_chk #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned DA_W  = 48,
   parameter int unsigned OFS_W = 8,
   parameter int unsigned ERR_W = 5,
   parameter logic [OFS_W-1:0] OFS_TX = 8'h7C,
   parameter logic [OFS_W-1:0] OFS_RX = 8'h7D,
   parameter logic [CNT_W-1:0] IRQ_AT = 8'hC0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stat_en,
   input logic             rx_evt,
   input logic [DA_W-1:0]  rx_da,
   input logic [ERR_W-1:0] rx_err,
   input logic             tx_evt,
   input logic [DA_W-1:0]  tx_da,
   input logic             rd_stb,
   input logic [OFS_W-1:0] rd_ofs,
   input logic [CNT_W-1:0] rd_data,
   input logic             irq_clr,
   input logic             upd_irq,
   input logic [CNT_W-1:0] cnt_tx,
   input logic [CNT_W-1:0] cnt_rx
);
   logic rd_tx, rd_rx, rd_other, tx_good, rx_good;
   assign rd_tx    = rd_stb && rd_ofs == OFS_TX;
   assign rd_rx    = rd_stb && rd_ofs == OFS_RX;
   assign rd_other = rd_stb && !rd_tx && !rd_rx;
   assign tx_good  = stat_en && tx_evt && (tx_da == {DA_W{1'b1}});
   assign rx_good  = stat_en && rx_evt && (rx_da == {DA_W{1'b1}}) && (rx_err == '0);

   p_nonbcast_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_evt && tx_da != {DA_W{1'b1}} && !rd_tx) |=> cnt_tx == $past(cnt_tx));

   p_rx_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_evt && rx_err != '0 && !rd_rx) |=> cnt_rx == $past(cnt_rx));

   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_good && !rd_tx && cnt_tx == {CNT_W{1'b1}}) |=> cnt_tx == '0);

   p_rdclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rx && !rx_evt) |=> cnt_rx == '0);

   p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_en && !rd_stb) |=> ($stable(cnt_tx) && $stable(cnt_rx)));

   p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(upd_irq) |-> (cnt_tx == IRQ_AT || cnt_rx == IRQ_AT));

   p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_irq && !irq_clr) |=> upd_irq);

   p_rd_evt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_tx && tx_good) |=> cnt_tx == CNT_W'(1));

   p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_other || !rd_stb) |-> rd_data == '0);

   p_rx_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_good && !rd_rx) |=> $stable(cnt_rx));
endmodule

bind bcast_stats bcast_stats_chk #(
   .CNT_W(CNT_W), .DA_W(DA_W), .OFS_W(OFS_W), .ERR_W(bcast_stats_pkg::N_ERR),
   .OFS_TX(OFS_TX), .OFS_RX(OFS_RX), .IRQ_AT(IRQ_AT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .stat_en(stat_en), .rx_evt(rx_evt), .rx_da(rx_da),
   .rx_err(rx_err), .tx_evt(tx_evt), .tx_da(tx_da), .rd_stb(rd_stb),
   .rd_ofs(rd_ofs), .rd_data(rd_data), .irq_clr(irq_clr), .upd_irq(upd_irq),
   .cnt_tx(cnt_tx_w), .cnt_rx(cnt_rx_w)
);

// File: tb/sim_bcast_stats.sv
module sim_bcast_stats;
   localparam logic [47:0] BC = '1;
   localparam logic [7:0]  A_TX = 8'h7C;
   localparam logic [7:0]  A_RX = 8'h7D;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        stat_en, rx_evt, tx_evt, rd_stb, irq_clr;
   logic [47:0] rx_da, tx_da;
   logic [4:0]  rx_err;
   logic [7:0]  rd_ofs, rd_data;
   logic        upd_irq;

   int checks = 0;
   int fails  = 0;
   logic [7:0] m_cnt [2];
   logic       m_irq;

   always #5 clk = ~clk;

   bcast_stats u0 (
      .clk(clk), .rst_n(rst_n), .stat_en(stat_en), .rx_evt(rx_evt), .rx_da(rx_da),
      .rx_err(rx_err), .tx_evt(tx_evt), .tx_da(tx_da), .rd_stb(rd_stb),
      .rd_ofs(rd_ofs), .rd_data(rd_data), .irq_clr(irq_clr), .upd_irq(upd_irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic counts(logic en, logic ev, logic [47:0] da, logic [4:0] er);
      return en && ev && (da == BC) && (er == 5'd0);
   endfunction

   // one clock cycle: check irq from previous edge, drive, check read, update model
   task automatic step(string tag, logic en, logic tev, logic [47:0] tda,
                       logic rev, logic [47:0] rda, logic [4:0] rer,
                       logic rs, logic [7:0] ofs, logic iclr);
      logic [1:0] inc, sel;
      logic       hit;
      logic [7:0] ex;
      @(negedge clk);
      chk({tag, " irq"}, {31'd0, upd_irq}, {31'd0, m_irq});
      stat_en = en; tx_evt = tev; tx_da = tda; rx_evt = rev; rx_da = rda;
      rx_err = rer; rd_stb = rs; rd_ofs = ofs; irq_clr = iclr;
      #1;
      inc[0] = counts(en, tev, tda, 5'd0);
      inc[1] = counts(en, rev, rda, rer);
      sel[0] = rs && ofs == A_TX;
      sel[1] = rs && ofs == A_RX;
      ex = sel[1] ? m_cnt[1] : (sel[0] ? m_cnt[0] : 8'h00);
      chk({tag, " rd_data"}, {24'd0, rd_data}, {24'd0, ex});
      hit = 1'b0;
      for (int c = 0; c < 2; c++) begin
         if (sel[c]) m_cnt[c] = inc[c] ? 8'd1 : 8'd0;
         else if (inc[c]) begin
            m_cnt[c] = m_cnt[c] + 8'd1;
            if (m_cnt[c] == 8'hC0) hit = 1'b1;
         end
      end
      m_irq = hit ? 1'b1 : (iclr ? 1'b0 : m_irq);
   endtask

   task automatic rd(string tag, logic [7:0] ofs);
      step(tag, 1'b1, 1'b0, '0, 1'b0, '0, 5'd0, 1'b1, ofs, 1'b0);
   endtask

   task automatic tx_bc(string tag, int n);
      for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b1, BC, 1'b0, '0, 5'd0, 1'b0, 8'h00, 1'b0);
   endtask

   task automatic rx_bc(string tag, int n);
      for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b0, '0, 1'b1, BC, 5'd0, 1'b0, 8'h00, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4021));
      rst_n = 1'b0; stat_en = 1'b0; rx_evt = 1'b0; tx_evt = 1'b0; rd_stb = 1'b0;
      irq_clr = 1'b0; rx_da = '0; tx_da = '0; rx_err = '0; rd_ofs = '0;
      m_cnt[0] = 8'd0; m_cnt[1] = 8'd0; m_irq = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 rd_data idle", {24'd0, rd_data}, 32'd0);
      chk("R1 irq", {31'd0, upd_irq}, 32'd0);
      rst_n = 1'b1;
      rd("R1", A_TX);
      rd("R1", A_RX);

      // R2 / R6: count, read, read again
      tx_bc("R2", 3);
      rx_bc("R2", 2);
      rd("R2", A_TX);
      rd("R2", A_RX);
      rd("R6", A_TX);
      rd("R6", A_RX);

      // R3: near-miss and multicast addresses
      step("R3", 1'b1, 1'b1, 48'h01005E000001, 1'b1, 48'hFFFFFFFFFFFE, 5'd0, 1'b0, 8'h00, 1'b0);
      step("R3", 1'b1, 1'b1, 48'h7FFFFFFFFFFF, 1'b1, 48'h333300000001, 5'd0, 1'b0, 8'h00, 1'b0);
      rd("R3", A_TX);
      rd("R3", A_RX);

      // R4: each error flag alone, then all clean
      for (int b = 0; b < 5; b++)
         step("R4", 1'b1, 1'b0, '0, 1'b1, BC, 5'(1 << b), 1'b0, 8'h00, 1'b0);
      rx_bc("R4", 1);
      rd("R4", A_RX);

      // R7: disabled
      for (int i = 0; i < 4; i++)
         step("R7", 1'b0, 1'b1, BC, 1'b1, BC, 5'd0, 1'b0, 8'h00, 1'b0);
      rd("R7", A_TX);
      rd("R7", A_RX);

      // R5 + R8: 256 transmit events cross 0xC0 and wrap
      tx_bc("R8", 192);
      step("R8", 1'b1, 1'b0, '0, 1'b0, '0, 5'd0, 1'b0, 8'h00, 1'b0);
      tx_bc("R5", 64);
      rd("R5", A_TX);

      // R9: sticky, then clear
      for (int i = 0; i < 3; i++) step("R9", 1'b1, 1'b0, '0, 1'b0, '0, 5'd0, 1'b0, 8'h00, 1'b0);
      step("R9", 1'b1, 1'b0, '0, 1'b0, '0, 5'd0, 1'b0, 8'h00, 1'b1);
      step("R9", 1'b1, 1'b0, '0, 1'b0, '0, 5'd0, 1'b0, 8'h00, 1'b0);

      // R8 on receive side, with set winning over a same-cycle clear (R9)
      rx_bc("R8", 191);
      step("R9", 1'b1, 1'b0, '0, 1'b1, BC, 5'd0, 1'b0, 8'h00, 1'b1);
      step("R9", 1'b1, 1'b0, '0, 1'b0, '0, 5'd0, 1'b0, 8'h00, 1'b0);
      step("R9", 1'b1, 1'b0, '0, 1'b0, '0, 5'd0, 1'b0, 8'h00, 1'b1);
      rd("R8", A_RX);

      // R10: read with a same-cycle counted event
      tx_bc("R10", 5);
      step("R10", 1'b1, 1'b1, BC, 1'b0, '0, 5'd0, 1'b1, A_TX, 1'b0);
      rd("R10", A_TX);

      // R11: unmapped offsets
      tx_bc("R11", 2);
      rx_bc("R11", 3);
      step("R11", 1'b1, 1'b0, '0, 1'b0, '0, 5'd0, 1'b1, 8'h7E, 1'b0);
      step("R11", 1'b1, 1'b0, '0, 1'b0, '0, 5'd0, 1'b1, 8'h00, 1'b0);
      rd("R11", A_TX);
      rd("R11", A_RX);

      // seeded random mix
      for (int i = 0; i < 3000; i++) begin
         logic [47:0] ta, ra;
         logic [4:0]  re;
         logic [7:0]  of;
         int          k;
         ta = ($urandom_range(0, 9) < 6) ? BC : {$urandom(), 16'($urandom())};
         ra = ($urandom_range(0, 9) < 6) ? BC : {$urandom(), 16'($urandom())};
         re = ($urandom_range(0, 9) < 7) ? 5'd0 : 5'($urandom());
         k  = $urandom_range(0, 2);
         of = (k == 0) ? A_TX : ((k == 1) ? A_RX : 8'($urandom()));
         step("RND", ($urandom_range(0, 9) != 0), ($urandom_range(0, 9) < 4), ta,
              ($urandom_range(0, 9) < 4), ra, re, ($urandom_range(0, 19) == 0), of,
              ($urandom_range(0, 19) == 0));
      end
      step("R1 end", 1'b1, 1'b0, '0, 1'b0, '0, 5'd0, 1'b0, 8'h00, 1'b0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule